// File: doc/BRIEF.md
# Serial Converter Host Reader with Frame Validation

This block is the host side of a two-wire, read-only link to a sigma-delta converter. A single shared line carries both the "result ready" indication and the serial data. While the reader is waiting, a high-to-low transition on that line means that a conversion is available. The reader then drives 24 serial clock pulses. The low and high times of each pulse come from input ports. The reader shifts in a 16-bit result, most significant bit first, followed by an 8-bit status byte.

The status byte is checked against its fixed fields. The result is converted from offset binary to signed two's complement. The result and its three flags leave the block on a valid/ready stream.

Back-pressure rules for the output stream:
- `out_valid` stays high, and the data and flags stay frozen, until a cycle in which `out_ready` is high.
- No new read is started while a result is waiting to be accepted. A conversion that completes in that interval is therefore skipped.

The reader also has two further functions:
- A request input drives the converter's power-down/reset pin low for a fixed number of cycles. The reader then ignores the shared line for a settling interval.
- A one-cycle timeout pulse is raised whenever no ready edge arrives within a programmable number of cycles.

Top module: `adc_host_reader`

## Requirements
- R1: After `rst_n` is released, `dev_rst_n` is 1, `sclk` is 1, `out_valid` is 0 and `read_timeout` is 0. The reader is waiting for a ready edge.
- R2: A read starts only on a high-to-low transition of the synchronised `sdo` line while the reader is waiting. Each read produces exactly 24 falling edges on `sclk`. Between reads, `sclk` stays high.
- R3: Each serial clock low phase lasts `sclk_lo_cyc` cycles and each high phase lasts `sclk_hi_cyc` cycles, with 0 treated as 1. `sclk_lo_cyc` must be at least 3 so that the two-stage synchroniser settles before sampling.
- R4: Bits are sampled at each rising `sclk` edge and shifted in MSB first. Frame bits 23..8 are the result. Bits 7..0 form the status byte: bit 7 ready, bit 6 zero, bit 5 range error, bits 4..3 identity, bits 2..0 pattern.
- R5: `out_data` equals the 16-bit result with its most significant bit inverted (offset binary to two's complement).
- R6: `err_range` equals status bit 5.
- R7: `err_pattern` is 1 exactly when status bits 2..0 differ from 3'b101.
- R8: `err_id` is 1 exactly when status bits 4..3 differ from 2'b01.
- R9: Once `out_valid` rises, it stays high with `out_data` and the flags unchanged until `out_ready` is seen high, and falls in the next cycle. While a result is held, a ready edge on `sdo` starts no read.
- R10: While waiting, if `timeout_cyc` (nonzero) cycles pass with no ready edge, `read_timeout` pulses for one cycle and the count restarts.
- R11: A `reset_req` cycle aborts any read and drives `dev_rst_n` low for exactly `RST_LOW_CYC` cycles. For the following `SETTLE_CYC` cycles the `sdo` line is ignored, and then waiting resumes.
- R12: While a frame is being clocked, transitions on `sdo` start no additional read and produce no additional `sclk` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset of the reader |
| reset_req | input | 1 | One-cycle request to pulse the converter reset pin |
| sclk_hi_cyc | input | PH_W | Serial clock high phase length in cycles |
| sclk_lo_cyc | input | PH_W | Serial clock low phase length in cycles |
| timeout_cyc | input | TMO_W | Ready-wait timeout in cycles, 0 disables |
| sdo | input | 1 | Shared ready/data line from the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| dev_rst_n | output | 1 | Power-down/reset pin to the converter, active low |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_data | output | 16 | Result in two's complement |
| err_range | output | 1 | Converter reported input out of range |
| err_pattern | output | 1 | Status pattern field differs from 101 |
| err_id | output | 1 | Status identity field differs from 01 |
| read_timeout | output | 1 | One-cycle pulse on ready-wait timeout |

## Verification
The assertions take the following for granted about the block's inputs:
- The phase-length and timeout inputs stay constant for the length of a frame.
- `reset_req` and `out_ready` are driven synchronously to `clk`.
- The converter changes `sdo` only shortly after a falling `sclk` edge, and releases the line high after the last rising edge.

The stimulus respects these conditions. A converter model in the bench presents each bit two nanoseconds after the falling edge and raises the line right after the 24th rising edge. Configuration is changed only between frames, with `sclk_lo_cyc` kept at three or more. Deliberate low levels on `sdo` during holding and settling are applied only at negative clock edges.

// File: rtl/adc_reader_pkg.sv
package adc_reader_pkg;
  localparam int RES_W   = 16;
  localparam int STAT_W  = 8;
  localparam int FRAME_W = RES_W + STAT_W;

  // status byte field positions (decoded by the frame checker)
  localparam int ERR_POS = 5;
  localparam int ID_HI   = 4;
  localparam int ID_LO   = 3;
  localparam int PAT_HI  = 2;

  localparam logic [1:0] ID_EXPECT  = 2'b01;
  localparam logic [2:0] PAT_EXPECT = 3'b101;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_SHIFT,
    ST_HOLD,
    ST_PDN,
    ST_SETTLE
  } rd_state_t;
endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/adc_sclk_shifter.sv
module adc_sclk_shifter #(
  parameter int FRAME_W = 24,
  parameter int PH_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort,
  input  logic               start,
  input  logic [PH_W-1:0]    hi_cyc,
  input  logic [PH_W-1:0]    lo_cyc,
  input  logic               line_s,
  output logic               sclk,
  output logic               done,
  output logic [FRAME_W-1:0] frame
);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  logic            busy;
  logic            phase_hi;
  logic [PH_W-1:0] cnt;
  logic [BW-1:0]   bitn;
  logic [PH_W-1:0] hi_eff, lo_eff;

  assign hi_eff = (hi_cyc == '0) ? PH_W'(1) : hi_cyc;
  assign lo_eff = (lo_cyc == '0) ? PH_W'(1) : lo_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase_hi <= 1'b1;
      sclk     <= 1'b1;
      done     <= 1'b0;
      cnt      <= '0;
      bitn     <= '0;
      frame    <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        sclk <= 1'b1;
      end else if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          sclk     <= 1'b0;
          phase_hi <= 1'b0;
          cnt      <= lo_eff - PH_W'(1);
          bitn     <= '0;
        end
      end else if (!phase_hi) begin
        if (cnt == '0) begin
          // rising edge: the bit has been stable since the falling edge
          frame <= {frame[FRAME_W-2:0], line_s};
          sclk  <= 1'b1;
          if (bitn == LAST_BIT) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            phase_hi <= 1'b1;
            cnt      <= hi_eff - PH_W'(1);
          end
        end else begin
          cnt <= cnt - PH_W'(1);
        end
      end else begin
        if (cnt == '0) begin
          phase_hi <= 1'b0;
          sclk     <= 1'b0;
          cnt      <= lo_eff - PH_W'(1);
          bitn     <= bitn + BW'(1);
        end else begin
          cnt <= cnt - PH_W'(1);
        end
      end
    end
  end

  // R3: a low phase longer than one cycle is not cut short
  p_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || abort)
    ($fell(sclk) && lo_eff > PH_W'(1)) |=> !sclk);
  // R3: a mid-frame high phase longer than one cycle is not cut short
  p_high_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || abort)
    ($rose(sclk) && busy && hi_eff > PH_W'(1)) |=> sclk);
  // R2: a completed frame leaves the clock idle high
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk && !busy));
endmodule

// File: rtl/adc_frame_check.sv
module adc_frame_check
  import adc_reader_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output logic [RES_W-1:0]   data,
  output logic               range_err,
  output logic               pat_err,
  output logic               id_err
);
  logic [RES_W-1:0]  res;
  logic [STAT_W-1:0] stat;

  assign res  = frame[FRAME_W-1:STAT_W];
  assign stat = frame[STAT_W-1:0];

  // offset binary to two's complement
  assign data      = {~res[RES_W-1], res[RES_W-2:0]};
  assign range_err = stat[ERR_POS];
  assign pat_err   = (stat[PAT_HI:0] != PAT_EXPECT);
  assign id_err    = (stat[ID_HI:ID_LO] != ID_EXPECT);
endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader
  import adc_reader_pkg::*;
#(
  parameter int PH_W        = 8,
  parameter int TMO_W       = 24,
  parameter int RST_LOW_CYC = 16,
  parameter int SETTLE_CYC  = 2_500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic [PH_W-1:0]  sclk_hi_cyc,
  input  logic [PH_W-1:0]  sclk_lo_cyc,
  input  logic [TMO_W-1:0] timeout_cyc,
  input  logic             sdo,
  output logic             sclk,
  output logic             dev_rst_n,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_data,
  output logic             err_range,
  output logic             err_pattern,
  output logic             err_id,
  output logic             read_timeout
);
  localparam int WAIT_MAX = (RST_LOW_CYC > SETTLE_CYC) ? RST_LOW_CYC : SETTLE_CYC;
  localparam int CW       = $clog2(WAIT_MAX + 1);

  rd_state_t          state;
  logic [CW-1:0]      wcnt;
  logic [TMO_W-1:0]   tmo_cnt;
  logic               line_s, line_prev, ready_edge;
  logic               sh_done;
  logic [FRAME_W-1:0] sh_frame;
  logic [RES_W-1:0]   dec_data;
  logic               dec_range, dec_pat, dec_id;

  adc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sdo), .dout(line_s)
  );

  adc_sclk_shifter #(.FRAME_W(FRAME_W), .PH_W(PH_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(reset_req),
    .start(state == ST_WAIT && ready_edge && !reset_req),
    .hi_cyc(sclk_hi_cyc), .lo_cyc(sclk_lo_cyc), .line_s(line_s),
    .sclk(sclk), .done(sh_done), .frame(sh_frame)
  );

  adc_frame_check u_check (
    .frame(sh_frame), .data(dec_data),
    .range_err(dec_range), .pat_err(dec_pat), .id_err(dec_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) line_prev <= 1'b1;
    else        line_prev <= line_s;
  end
  assign ready_edge = line_prev && !line_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_WAIT;
      wcnt         <= '0;
      tmo_cnt      <= '0;
      read_timeout <= 1'b0;
      out_data     <= '0;
      err_range    <= 1'b0;
      err_pattern  <= 1'b0;
      err_id       <= 1'b0;
    end else begin
      read_timeout <= 1'b0;
      if (reset_req) begin
        state <= ST_PDN;
        wcnt  <= CW'(RST_LOW_CYC - 1);
      end else begin
        case (state)
          ST_WAIT: begin
            if (ready_edge) begin
              state   <= ST_SHIFT;
              tmo_cnt <= '0;
            end else if (timeout_cyc != '0 && tmo_cnt >= timeout_cyc - TMO_W'(1)) begin
              read_timeout <= 1'b1;
              tmo_cnt      <= '0;
            end else begin
              tmo_cnt <= tmo_cnt + TMO_W'(1);
            end
          end
          ST_SHIFT: begin
            if (sh_done) begin
              state       <= ST_HOLD;
              out_data    <= dec_data;
              err_range   <= dec_range;
              err_pattern <= dec_pat;
              err_id      <= dec_id;
            end
          end
          ST_HOLD: begin
            if (out_ready) begin
              state   <= ST_WAIT;
              tmo_cnt <= '0;
            end
          end
          ST_PDN: begin
            if (wcnt == '0) begin
              state <= ST_SETTLE;
              wcnt  <= CW'(SETTLE_CYC - 1);
            end else begin
              wcnt <= wcnt - CW'(1);
            end
          end
          default: begin
            if (wcnt == '0) begin
              state   <= ST_WAIT;
              tmo_cnt <= '0;
            end else begin
              wcnt <= wcnt - CW'(1);
            end
          end
        endcase
      end
    end
  end

  assign dev_rst_n = (state != ST_PDN);
  assign out_valid = (state == ST_HOLD);

  // R2: the serial clock rests high outside a frame
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> sclk);
  // R9: a held result does not move under back-pressure
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !reset_req) |=>
      (out_valid && $stable(out_data) && $stable(err_range) &&
       $stable(err_pattern) && $stable(err_id)));
  // R9: an accepted result is withdrawn in the next cycle
  p_accept_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
  // R10: the timeout is a single-cycle pulse
  p_tmo_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (read_timeout && timeout_cyc > TMO_W'(1)) |=> !read_timeout);
  // R11: no clocking and no result while the converter is held in reset
  p_pdn_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |-> (sclk && !out_valid));
endmodule

// File: tb/adc_host_reader_test.sv
module adc_host_reader_test;
  localparam int RLOW = 12;
  localparam int SETL = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reset_req;
  logic [7:0]  hi_cyc, lo_cyc;
  logic [23:0] tmo_cyc;
  logic        sdo;
  logic        sclk, dev_rst_n, out_valid, out_ready;
  logic [15:0] out_data;
  logic        err_range, err_pattern, err_id, read_timeout;

  always #5 clk = ~clk;

  adc_host_reader #(.RST_LOW_CYC(RLOW), .SETTLE_CYC(SETL)) uut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
    .sclk_hi_cyc(hi_cyc), .sclk_lo_cyc(lo_cyc), .timeout_cyc(tmo_cyc),
    .sdo(sdo), .sclk(sclk), .dev_rst_n(dev_rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err_range(err_range), .err_pattern(err_pattern), .err_id(err_id),
    .read_timeout(read_timeout)
  );

  // {raw frame, expected data, range, pattern, id}
  localparam logic [42:0] VEC [0:7] = '{
    {24'h80000D, 16'h0000, 3'b000},
    {24'hFFFF0D, 16'h7FFF, 3'b000},
    {24'h00000D, 16'h8000, 3'b000},
    {24'h12342D, 16'h9234, 3'b100},
    {24'hABCD0C, 16'h2BCD, 3'b010},
    {24'h5A5A15, 16'hDA5A, 3'b001},
    {24'h7FFF08, 16'hFFFF, 3'b010},
    {24'h3C3C75, 16'hBC3C, 3'b101}
  };

  int n_chk = 0, n_bad = 0;
  int falls = 0, tmo_seen = 0;
  int run_len = 0, low_min = 0, low_max = 0, high_min = 0;
  int cyc = 0;
  logic sclk_q = 1'b1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // observation only: serial clock edges, run lengths and timeout pulses
  always @(negedge clk) begin
    cyc++;
    if (read_timeout) tmo_seen++;
    if (sclk !== sclk_q) begin
      if (sclk_q == 1'b0) begin
        if (low_min == 0 || run_len < low_min) low_min = run_len;
        if (run_len > low_max) low_max = run_len;
      end else begin
        if (high_min == 0 || run_len < high_min) high_min = run_len;
        falls++;
      end
      run_len = 1;
    end else begin
      run_len++;
    end
    sclk_q = sclk;
  end

  task automatic clr_mon();
    low_min = 0; low_max = 0; high_min = 0;
  endtask

  // converter model: ready low, then one bit after each falling edge
  task automatic send_frame(input logic [23:0] raw);
    @(negedge clk);
    sdo = 1'b0;
    for (int b = 23; b >= 0; b--) begin
      @(negedge sclk);
      #2 sdo = raw[b];
    end
    @(posedge sclk);
    #2 sdo = 1'b1;
  endtask

  task automatic wait_valid(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected < 150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic seen;
    int f0, t0, w;
    rst_n = 1'b0; reset_req = 1'b0; sdo = 1'b1; out_ready = 1'b1;
    hi_cyc = 8'd5; lo_cyc = 8'd4; tmo_cyc = 24'hFFFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(dev_rst_n == 1'b1, "R1 dev_rst_n", dev_rst_n, 1);
    chk(sclk == 1'b1, "R1 sclk", sclk, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(read_timeout == 1'b0, "R1 read_timeout", read_timeout, 0);

    // table-driven frames with varying phase lengths
    for (int i = 0; i < 8; i++) begin
      lo_cyc = 8'(3 + i % 3);
      hi_cyc = 8'(1 + i % 4);
      clr_mon();
      f0 = falls;
      send_frame(VEC[i][42:19]);
      wait_valid(seen);
      chk(seen, "R2 read completes", seen, 1);
      chk(out_data == VEC[i][18:3], "R4 R5 out_data", out_data, VEC[i][18:3]);
      chk(err_range == VEC[i][2], "R6 err_range", err_range, VEC[i][2]);
      chk(err_pattern == VEC[i][1], "R7 err_pattern", err_pattern, VEC[i][1]);
      chk(err_id == VEC[i][0], "R8 err_id", err_id, VEC[i][0]);
      chk(falls - f0 == 24, "R2 R12 sclk falls per frame", falls - f0, 24);
      chk(low_min == lo_cyc && low_max == lo_cyc, "R3 low phase", low_max, lo_cyc);
      chk(high_min == hi_cyc, "R3 high phase", high_min, hi_cyc);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 drop after accept", out_valid, 0);
    end
    chk(tmo_seen == 0, "R10 no timeout while disabled-long", tmo_seen, 0);

    // R9: back-pressure holds the result and blocks new reads
    out_ready = 1'b0;
    lo_cyc = 8'd4; hi_cyc = 8'd3;
    send_frame(24'h80010D);
    wait_valid(seen);
    chk(seen && out_data == 16'h0001, "R9 held data", out_data, 16'h0001);
    f0 = falls;
    sdo = 1'b0;
    repeat (30) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == 16'h0001, "R9 still held", out_valid, 1);
    chk(falls == f0, "R9 no read while holding", falls - f0, 0);
    sdo = 1'b1;
    repeat (5) @(negedge clk);

    // R10: timeout pulse period after acceptance
    tmo_cyc = 24'd100;
    tmo_seen = 0;
    out_ready = 1'b1;
    w = 0;
    while (tmo_seen == 0 && w < 300) begin @(negedge clk); w++; end
    chk(w >= 95 && w <= 110, "R10 first timeout", w, 100);
    t0 = tmo_seen; w = 0;
    while (tmo_seen == t0 && w < 300) begin @(negedge clk); w++; end
    chk(w >= 98 && w <= 102, "R10 restart period", w, 100);
    tmo_cyc = 24'hFFFFFF;

    // R11: reset pulse length and ignored line during settling
    @(negedge clk);
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
    w = 0;
    while (dev_rst_n == 1'b0 && w < 100) begin w++; @(negedge clk); end
    chk(w == RLOW, "R11 reset low length", w, RLOW);
    f0 = falls;
    repeat (10) @(negedge clk);
    sdo = 1'b0;
    repeat (20) @(negedge clk);
    sdo = 1'b1;
    repeat (120) @(negedge clk);
    chk(falls == f0 && out_valid == 1'b0, "R11 line ignored while settling", falls - f0, 0);
    repeat (SETL) @(negedge clk);
    send_frame(24'hC0000D);
    wait_valid(seen);
    chk(seen && out_data == 16'h4000, "R11 read after settle", out_data, 16'h4000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule